// File: doc/BRIEF.md
# TDM Serial Frame Generator

This block is the master end of a time-division-multiplexed serial link to a signal processor. It divides the system clock down to a bit rate and publishes that rate as a one-cycle strobe, `sclk_en`. It shifts out a frame of fixed-width time slots on `sdo`, shifts in the matching bits from `sdi`, and marks each frame with a sync pulse one bit wide on `fsync`. That pulse occupies the bit period just before the first data bit of the frame it announces.

After reset the frame holds `SLOTS` slots of `SLOT_W` bits each (12 x 16 = 192 bit periods by default), and frames follow each other with no gap. The sync pulse then shares a bit period with the last data bit of the frame before it. A longer frame period, counted in bit periods, can be written through `rate_load`/`rate_period` so that frames arrive at a converter's sample rate. The extra bit periods after the last slot are idle, with `sdo` held low. The block treats every slot word as plain data. Flow-control flags inside the slots, and their meaning, belong to the logic on either side.

Parallel transmit words for all slots are captured together when the sync pulse is issued. Each received slot is delivered as a parallel word, tagged with its slot number, through a single-cycle strobe. `SLOT_W` must be a power of two.

Top module: `tdm_frame_gen`

## Requirements
- R1: `fsync` is high for exactly one bit period per frame, and that bit period immediately precedes the bit period that carries bit 15 of slot 0.
- R2: After reset the frame period is 192 bit periods (12 slots x 16 bits), so consecutive sync pulses are 192 bit periods apart.
- R3: Each slot is sent most significant bit first. Slots go out in increasing order, and slot s carries `tx_words[16*s+15 : 16*s]`.
- R4: `tx_words` is sampled only on the clock that raises `fsync`. Changing it during a frame does not alter the bits of that frame.
- R5: A programmed period P (P >= 192) spaces sync pulses P bit periods apart. Bit periods 192 to P-1 of a frame are idle, with `sdo` low.
- R6: A programmed value below 192 is treated as 192 (back-to-back framing).
- R7: A new period takes effect at the next frame boundary, never inside a frame. If several loads arrive before a boundary, the last one wins.
- R8: After bit 0 of each slot has been sampled from `sdi`, `rx_valid` is high for one clock. At that time `rx_word` holds the 16 bits of the slot (first received bit in bit 15) and `rx_slot` holds the slot number, 0 to 11.
- R9: `sclk_en` is high for one clock every `CLK_DIV` clocks. `fsync` and `sdo` change only on a clock edge at which `sclk_en` is high.
- R10: The reset (synchronous, active high) drives `fsync`, `sdo` and `rx_valid` low. The first sync pulse appears at the first bit strobe after reset, and no slot word is delivered before the first frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_load | input | 1 | Capture `rate_period` as the pending frame period |
| rate_period | input | PER_W (16) | Requested frame period in bit periods |
| tx_words | input | SLOTS*SLOT_W (192) | Transmit words, slot s in bits [16s+15:16s] |
| sdi | input | 1 | Serial data in |
| sclk_en | output | 1 | Bit strobe, one clock every CLK_DIV clocks |
| fsync | output | 1 | Frame sync, one bit period before each frame |
| sdo | output | 1 | Serial data out |
| rx_valid | output | 1 | Received word strobe |
| rx_slot | output | $clog2(SLOTS) (4) | Slot number of `rx_word` |
| rx_word | output | SLOT_W (16) | Received slot word |

## Verification
A wrong bit-position count moves `fsync` away from its expected bit period, which is visible at the very next sync. It also corrupts the first data bit that follows, either in order or in slot placement. A period register that takes a new value at the wrong time shows up as a sync spacing that is wrong for exactly one frame. A stale or overwritten transmit shadow is exposed within one frame, because the bench changes `tx_words` mid-frame. With `sdo` looped back to `sdi`, any slip in receive alignment produces a wrong `rx_word` or `rx_slot` on the strobe that ends the affected slot, at most 16 bit periods later.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int DEF_SLOTS   = 12;
  localparam int DEF_SLOT_W  = 16;
  localparam int DEF_PER_W   = 16;
  localparam int DEF_CLK_DIV = 2;
endpackage

// File: rtl/tdm_bit_tick.sv
// Bit-rate strobe: one clock high every DIV clocks.
module tdm_bit_tick #(
  parameter int DIV = 2,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [CW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) dcnt <= '0;
    else if (dcnt == CW'(DIV - 1)) dcnt <= '0;
    else dcnt <= dcnt + 1'b1;
  end

  assign tick = (dcnt == CW'(DIV - 1));
endmodule

// File: rtl/tdm_frame_ctr.sv
// Bit position within the frame, frame period with boundary-aligned update.
module tdm_frame_ctr #(
  parameter int FRAME_BITS = 192,
  parameter int PER_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rate_load,
  input  logic [PER_W-1:0] rate_period,
  output logic [PER_W-1:0] cnt,
  output logic [PER_W-1:0] nxt,
  output logic             sync_nxt,
  output logic             wrap,
  output logic             live
);
  localparam logic [PER_W-1:0] FB_P = PER_W'(FRAME_BITS);

  logic [PER_W-1:0] per_cur, per_pend, req, last_pos;
  logic             pend, at_last;

  always_comb begin
    last_pos = per_cur - 1'b1;
    at_last  = (cnt == last_pos);
    nxt      = at_last ? '0 : cnt + 1'b1;
    wrap     = tick & at_last;
    sync_nxt = tick & (nxt == last_pos);
    req      = (rate_period < FB_P) ? FB_P : rate_period;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= FB_P - PER_W'(2);
      per_cur  <= FB_P;
      per_pend <= FB_P;
      pend     <= 1'b0;
      live     <= 1'b0;
    end else begin
      if (tick) cnt <= nxt;
      if (wrap) begin
        live <= 1'b1;
        if (pend) per_cur <= per_pend;
      end
      if (rate_load) begin
        per_pend <= req;
        pend     <= 1'b1;
      end else if (wrap) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_path.sv
// Frame sync and transmit shifter; slot words captured at the sync edge.
module tdm_tx_path #(
  parameter int SLOT_W     = 16,
  parameter int FRAME_BITS = 192,
  parameter int PER_W      = 16,
  localparam int IW        = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  sync_nxt,
  input  logic                  wrap,
  input  logic                  live,
  input  logic [PER_W-1:0]      nxt,
  input  logic [FRAME_BITS-1:0] tx_words,
  output logic                  fsync,
  output logic                  sdo
);
  logic [FRAME_BITS-1:0] shadow;
  logic [IW-1:0]         idx;
  logic                  in_data, bit_c;

  always_comb begin
    in_data = (nxt < PER_W'(FRAME_BITS));
    // slot*SLOT_W + (SLOT_W-1-bit): low bits of the position are mirrored
    idx     = nxt[IW-1:0] ^ IW'(SLOT_W - 1);
    bit_c   = shadow[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      fsync  <= 1'b0;
      sdo    <= 1'b0;
    end else if (tick) begin
      fsync <= sync_nxt;
      if (sync_nxt) shadow <= tx_words;
      sdo <= (in_data && (live || wrap)) ? bit_c : 1'b0;
    end
  end
endmodule

// File: rtl/tdm_rx_path.sv
// Receive deserializer: word strobe with slot index after each slot's bit 0.
module tdm_rx_path #(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 12,
  parameter int PER_W  = 16,
  localparam int BW    = $clog2(SLOT_W),
  localparam int SIW   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              live,
  input  logic [PER_W-1:0]  cnt,
  input  logic              sdi,
  output logic              rx_valid,
  output logic [SIW-1:0]    rx_slot,
  output logic [SLOT_W-1:0] rx_word
);
  logic [SLOT_W-2:0] sh;
  logic              take, slot_end;

  always_comb begin
    take     = tick && live && (cnt < PER_W'(SLOTS * SLOT_W));
    slot_end = (cnt[BW-1:0] == {BW{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      rx_valid <= 1'b0;
      rx_slot  <= '0;
      rx_word  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (take) begin
        sh <= {sh[SLOT_W-3:0], sdi};
        if (slot_end) begin
          rx_word  <= {sh, sdi};
          rx_slot  <= cnt[BW +: SIW];
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
  import tdm_pkg::*;
#(
  parameter int SLOTS   = DEF_SLOTS,
  parameter int SLOT_W  = DEF_SLOT_W,
  parameter int PER_W   = DEF_PER_W,
  parameter int CLK_DIV = DEF_CLK_DIV,
  localparam int FRAME_BITS = SLOTS * SLOT_W,
  localparam int SLOT_IW    = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rate_load,
  input  logic [PER_W-1:0]      rate_period,
  input  logic [FRAME_BITS-1:0] tx_words,
  input  logic                  sdi,
  output logic                  sclk_en,
  output logic                  fsync,
  output logic                  sdo,
  output logic                  rx_valid,
  output logic [SLOT_IW-1:0]    rx_slot,
  output logic [SLOT_W-1:0]     rx_word
);
  logic             tick, sync_nxt, wrap, live;
  logic [PER_W-1:0] cnt, nxt;

  tdm_bit_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  tdm_frame_ctr #(.FRAME_BITS(FRAME_BITS), .PER_W(PER_W)) u_ctr (
    .clk(clk), .rst(rst), .tick(tick),
    .rate_load(rate_load), .rate_period(rate_period),
    .cnt(cnt), .nxt(nxt), .sync_nxt(sync_nxt), .wrap(wrap), .live(live)
  );

  tdm_tx_path #(.SLOT_W(SLOT_W), .FRAME_BITS(FRAME_BITS), .PER_W(PER_W)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .sync_nxt(sync_nxt), .wrap(wrap),
    .live(live), .nxt(nxt), .tx_words(tx_words), .fsync(fsync), .sdo(sdo)
  );

  tdm_rx_path #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .PER_W(PER_W)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .live(live), .cnt(cnt), .sdi(sdi),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_word(rx_word)
  );

  assign sclk_en = tick;
endmodule

// File: rtl/tdm_frame_gen_chk.sv
module tdm_frame_gen_chk #(
  parameter int FRAME_BITS = 192,
  parameter int SLOTS      = 12,
  parameter int SIW        = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           sclk_en,
  input logic           fsync,
  input logic           sdo,
  input logic           rx_valid,
  input logic [SIW-1:0] rx_slot
);
  logic [31:0] tcount;
  logic        fs_d, seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcount <= '0;
      fs_d   <= 1'b0;
      seen   <= 1'b0;
    end else begin
      fs_d <= fsync;
      if (fsync && !fs_d) begin
        seen   <= 1'b1;
        tcount <= sclk_en ? 32'd1 : 32'd0;
      end else if (sclk_en && tcount != '1) begin
        tcount <= tcount + 32'd1;
      end
    end
  end

  // R9
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_en |=> ($stable(fsync) && $stable(sdo)));

  // R1
  sync_width_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync && sclk_en) |=> !fsync);

  // R5
  sync_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (fsync && !fs_d && seen) |-> (tcount >= 32'(FRAME_BITS)));

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  rx_slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (32'(rx_slot) < 32'(SLOTS)));
endmodule

bind tdm_frame_gen tdm_frame_gen_chk #(
  .FRAME_BITS(FRAME_BITS), .SLOTS(SLOTS), .SIW(SLOT_IW)
) u_chk (
  .clk(clk), .rst(rst), .sclk_en(sclk_en), .fsync(fsync), .sdo(sdo),
  .rx_valid(rx_valid), .rx_slot(rx_slot)
);

// File: tb/tdm_frame_gen_bench.sv
module tdm_frame_gen_bench;
  localparam int SLOTS = 12;
  localparam int SW    = 16;
  localparam int FB    = SLOTS * SW;
  localparam int DIV   = 2;
  localparam int SIW   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rate_load = 1'b0;
  logic [15:0]   rate_period = 16'd0;
  logic [FB-1:0] tx_words = '0;
  logic          sdi, sclk_en, fsync, sdo, rx_valid;
  logic [SIW-1:0] rx_slot;
  logic [SW-1:0]  rx_word;

  always #2.5 clk = ~clk;
  assign sdi = sdo;  // loopback

  tdm_frame_gen #(.SLOTS(SLOTS), .SLOT_W(SW), .PER_W(16), .CLK_DIV(DIV)) u_tdm_frame_gen (
    .clk(clk), .rst(rst), .rate_load(rate_load), .rate_period(rate_period),
    .tx_words(tx_words), .sdi(sdi), .sclk_en(sclk_en), .fsync(fsync), .sdo(sdo),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_word(rx_word)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  function automatic logic [15:0] wgen(input int f, input int s);
    if (s == 3) return 16'hFFFF;
    if (s == 7) return 16'h0000;
    return 16'((f * 40503 + s * 4369 + 23100) ^ (s << (f % 8)));
  endfunction

  task automatic load_frame(input int f);
    for (int s = 0; s < SLOTS; s++) tx_words[s*SW +: SW] = wgen(f, s);
  endtask

  // R9: strobe spacing
  int  gap = 0;
  bit  gap_seen = 0;
  always @(negedge clk) begin
    if (rst) begin
      gap = 0; gap_seen = 0;
    end else begin
      gap++;
      if (sclk_en) begin
        if (gap_seen) chk(gap == DIV, "R9", "sclk_en spacing", 32'(gap), 32'(DIV));
        gap = 0; gap_seen = 1;
      end
    end
  end

  task automatic next_bit();
    @(negedge clk);
    rate_load = 1'b0;
    while (!sclk_en) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic string per_tag(input int f);
    if (f == 1 || f == 6) return "R2";
    if (f == 3) return "R6";
    if (f == 4) return "R7";
    return "R5";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    int pos, per, pend_per, fr, since_sync, prev;
    bit pend, live, prev_live, have_sync, exp_fs, exp_sdo, exp_v;
    logic [FB-1:0] cur;
    logic [15:0] exp_sh;
    pos = FB - 2; per = FB; pend_per = FB; pend = 0; live = 0;
    fr = 0; since_sync = 0; have_sync = 0; cur = '0; exp_sh = '0;

    load_frame(0);
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(fsync == 1'b0, "R10", "fsync in reset", 32'(fsync), 0);
    chk(sdo == 1'b0, "R10", "sdo in reset", 32'(sdo), 0);
    chk(rx_valid == 1'b0, "R10", "rx_valid in reset", 32'(rx_valid), 0);
    rst = 1'b0;

    while (fr < 7) begin
      next_bit();
      prev = pos; prev_live = live;
      since_sync++;
      if (pos == per - 1) begin
        pos = 0;
        if (pend) begin per = pend_per; pend = 0; end
        live = 1; fr++;
      end else pos++;

      exp_fs = (pos == per - 1);
      // R1 sync placement; R10 for the first one after reset
      chk(fsync == exp_fs, (fr == 0) ? "R10" : "R1", "fsync", 32'(fsync), 32'(exp_fs));
      if (exp_fs) begin
        if (have_sync)
          chk(since_sync == per, per_tag(fr), "sync spacing", 32'(since_sync), 32'(per));
        since_sync = 0; have_sync = 1;
      end

      // R8 receive strobe from the previous bit
      exp_v = prev_live && (prev < FB) && (prev % SW == SW - 1);
      chk(rx_valid == exp_v, "R8", "rx_valid", 32'(rx_valid), 32'(exp_v));
      if (exp_v) begin
        chk(rx_word == exp_sh, "R8", "rx_word", 32'(rx_word), 32'(exp_sh));
        chk(32'(rx_slot) == 32'(prev / SW), "R8", "rx_slot", 32'(rx_slot), 32'(prev / SW));
      end

      // R3 bit order, R4 word capture, R5 idle low
      exp_sdo = (live && pos < FB) ? cur[(pos / SW) * SW + SW - 1 - pos % SW] : 1'b0;
      chk(sdo == exp_sdo, (pos >= FB) ? "R5" : ((pos >= 100) ? "R4" : "R3"),
          "sdo", 32'(sdo), 32'(exp_sdo));
      if (live && pos < FB) exp_sh = {exp_sh[14:0], exp_sdo};
      if (exp_fs) cur = tx_words;

      if (live && pos == 100) load_frame(fr + 1);
      if (live && pos == 50) begin
        case (fr)
          1: begin rate_period = 16'd200; pend_per = 200; end
          2: begin rate_period = 16'd100; pend_per = FB;  end  // R6 clamp
          3: begin rate_period = 16'd300; pend_per = 300; end
          4: begin rate_period = 16'd193; pend_per = 193; end
          default: begin rate_period = 16'd192; pend_per = FB; end
        endcase
        rate_load = 1'b1; pend = 1;
      end
      if (live && pos == 60 && fr == 3) begin
        // R7: second load before the boundary replaces the first
        rate_period = 16'd256; pend_per = 256; rate_load = 1'b1; pend = 1;
      end
    end

    report();
    $finish;
  end
endmodule